// File: doc/BRIEF.md
# Triggered Binary Hit Pipeline Readout

The block takes one binary comparator bit per strip channel on every bunch-crossing clock. It turns those bits into hit bits, in one of two selectable modes, and stores each crossing's hit word in a circular pipeline memory. The pipeline is written once per clock.

When a level-1 trigger arrives, the block reads the word stored a programmed number of clocks earlier. It places that word in an event buffer, together with the pipeline address and an error bit. Buffered events leave on a single serial line as fixed-length, unsparsified frames: a short header followed by one bit for every channel, whatever the occupancy.

A fast reset restarts the pointers, empties the buffer, clears the error state and stops any frame in progress. It does not clear the memory contents.

Top module: `l1_hit_readout`

## Requirements
- R1: With `hit_mode`=1 (level mode), the hit bit of a channel equals the comparator bit sampled at the same clock edge, for as long as the comparator stays high.
- R2: With `hit_mode`=0 (edge mode), a hit bit is set only for the clock at which the comparator is sampled high after being sampled low at the previous edge. A hit bit is never set at two consecutive clocks in this mode.
- R3: A trigger sampled at edge t with `latency`=L returns the hit word formed from the comparator sampled at edge t-L-1. L=0 selects the full depth of 256 clocks.
- R4: A frame is 140 bits, sent most significant first, in this order: start marker `11`, overflow flag, priming flag, the 8-bit pipeline address (MSB first), then channel bits from channel 127 down to channel 0.
- R5: The pipeline write address is 0 at the first edge after a fast reset and then increments by one per clock, modulo 256. The address field of a frame equals the write address at the trigger edge minus L, modulo 256.
- R6: When the line is idle, the first bit of a triggered frame appears after the edge following the trigger edge. Queued frames follow back to back, each lasting 140 clocks, and `sdo` is low when no frame is being sent.
- R7: The buffer holds up to 32 events. `buf_full` is high exactly while 32 events are stored and none has started transmission.
- R8: A trigger arriving while the buffer is full is dropped and sets a sticky overflow flag. That flag appears as 1 in every frame whose transmission starts after the drop.
- R9: The priming flag is 1 when fewer than L (or 256 for L=0) writes have occurred since the last fast reset, because the addressed word then predates that reset.
- R10: After a fast reset sampled at an edge, the next cycle shows `sdo`=0 and `buf_full`=0. The overflow flag is clear, and no earlier event is transmitted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fast_rst | input | 1 | Synchronous fast reset of pointers, buffer and flags |
| l1_trig | input | 1 | Level-1 trigger strobe, one event per high clock |
| hit_mode | input | 1 | 1 = level mode, 0 = edge mode |
| latency | input | 8 | Trigger latency in clocks (0 means 256) |
| comp_in | input | 128 | Comparator outputs, one per channel |
| sdo | output | 1 | Serial frame output |
| buf_full | output | 1 | Event buffer holds 32 events |

## Verification
The scoreboard fixes the edge at which each trigger is sampled and computes the matching comparator edge, t-L-1, from the recorded stimulus. It then predicts the frame's first bit one clock after the trigger edge, or 140 clocks after the previous frame started if that is later. The monitor samples `sdo` a quarter period after every rising edge and checks the start edge and each header field of every frame against that prediction. The overflow bit is predicted from the first dropped trigger and each frame's start edge. The buffer-full and fast-reset checks are taken in the cycle right after the edge that causes them.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  localparam int START_W = 2;
  localparam logic [START_W-1:0] START_MARK = 2'b11;
  localparam int FLAG_W = 2;
endpackage

// File: rtl/rdo_hit_detect.sv
module rdo_hit_detect #(
  parameter int N_CH = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            level_mode,
  input  logic [N_CH-1:0] comp,
  output logic [N_CH-1:0] hit
);
  logic [N_CH-1:0] prev_q;
  logic [N_CH-1:0] hit_d;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign hit_d[c] = level_mode ? comp[c] : (comp[c] & ~prev_q[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      hit    <= '0;
    end else begin
      prev_q <= comp;
      hit    <= hit_d;
    end
  end
endmodule

// File: rtl/rdo_pipeline.sv
module rdo_pipeline #(
  parameter int N_CH  = 128,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [N_CH-1:0] wdata,
  input  logic [AW-1:0]   lat,
  output logic [N_CH-1:0] rdata,
  output logic [AW-1:0]   raddr,
  output logic [AW-1:0]   wr_ptr,
  output logic            unprimed
);
  logic [N_CH-1:0] mem [DEPTH];
  logic [AW-1:0]   wr_q, wr_d;
  logic [AW:0]     fill_q, fill_d;
  logic [AW:0]     lat_eff;

  always_comb begin
    wr_d   = clr ? '0 : wr_q + 1'b1;
    fill_d = fill_q;
    if (clr)                             fill_d = '0;
    else if (fill_q != (AW+1)'(DEPTH))   fill_d = fill_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      fill_q <= '0;
    end else begin
      wr_q   <= wr_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    mem[wr_q] <= wdata;
  end

  always_comb begin
    raddr    = wr_q - lat;
    rdata    = mem[raddr];
    lat_eff  = (lat == '0) ? (AW+1)'(DEPTH) : {1'b0, lat};
    unprimed = fill_q < lat_eff;
    wr_ptr   = wr_q;
  end
endmodule

// File: rtl/rdo_event_fifo.sv
module rdo_event_fifo #(
  parameter int W     = 137,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] rp_q, rp_d, wp_q, wp_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          do_push, do_pop;

  always_comb begin
    full    = (cnt_q == (AW+1)'(DEPTH));
    empty   = (cnt_q == '0);
    do_push = push & ~full & ~clr;
    do_pop  = pop & ~empty & ~clr;
    rp_d    = rp_q;
    wp_d    = wp_q;
    cnt_d   = cnt_q;
    if (clr) begin
      rp_d  = '0;
      wp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = wp_q + 1'b1;
      if (do_pop)  rp_d = rp_q + 1'b1;
      if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end
    dout = mem[rp_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q  <= '0;
      wp_q  <= '0;
      cnt_q <= '0;
    end else begin
      rp_q  <= rp_d;
      wp_q  <= wp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end
endmodule

// File: rtl/rdo_serializer.sv
module rdo_serializer #(
  parameter int FW  = 140,
  localparam int CW = $clog2(FW+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          avail,
  input  logic [FW-1:0] frame,
  output logic          take,
  output logic          sdo
);
  logic [FW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    take  = avail & ~clr & (cnt_q <= CW'(1));
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (clr) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (take) begin
      sh_d  = frame;
      cnt_d = CW'(FW);
    end else if (cnt_q != '0) begin
      sh_d  = {sh_q[FW-2:0], 1'b0};
      cnt_d = cnt_q - 1'b1;
    end
    sdo = sh_q[FW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/l1_hit_readout.sv
module l1_hit_readout
  import rdo_pkg::*;
#(
  parameter int N_CH       = 128,
  parameter int PIPE_DEPTH = 256,
  parameter int BUF_DEPTH  = 32,
  localparam int AW        = $clog2(PIPE_DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fast_rst,
  input  logic            l1_trig,
  input  logic            hit_mode,
  input  logic [AW-1:0]   latency,
  input  logic [N_CH-1:0] comp_in,
  output logic            sdo,
  output logic            buf_full
);
  localparam int ENTRY_W = 1 + AW + N_CH;
  localparam int FRAME_W = START_W + 1 + ENTRY_W;

  logic [1:0]         rs_q;
  logic               rst_s;
  logic [N_CH-1:0]    hit_w;
  logic [N_CH-1:0]    rd_word;
  logic [AW-1:0]      rd_addr;
  logic [AW-1:0]      wr_ptr;
  logic               unprimed;
  logic [ENTRY_W-1:0] entry_in, entry_out;
  logic               fifo_empty, fifo_full, ser_take;
  logic               ovf_q, ovf_d;
  logic [FRAME_W-1:0] frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  rdo_hit_detect #(.N_CH(N_CH)) i_hit (
    .clk(clk), .rst_n(rst_s), .level_mode(hit_mode), .comp(comp_in), .hit(hit_w)
  );

  rdo_pipeline #(.N_CH(N_CH), .DEPTH(PIPE_DEPTH)) i_pipe (
    .clk(clk), .rst_n(rst_s), .clr(fast_rst), .wdata(hit_w), .lat(latency),
    .rdata(rd_word), .raddr(rd_addr), .wr_ptr(wr_ptr), .unprimed(unprimed)
  );

  assign entry_in = {unprimed, rd_addr, rd_word};

  rdo_event_fifo #(.W(ENTRY_W), .DEPTH(BUF_DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_s), .clr(fast_rst), .push(l1_trig), .din(entry_in),
    .pop(ser_take), .dout(entry_out), .empty(fifo_empty), .full(fifo_full)
  );

  always_comb begin
    ovf_d = ovf_q;
    if (fast_rst)                  ovf_d = 1'b0;
    else if (l1_trig && fifo_full) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign frame = {START_MARK, ovf_q, entry_out};

  rdo_serializer #(.FW(FRAME_W)) i_ser (
    .clk(clk), .rst_n(rst_s), .clr(fast_rst), .avail(~fifo_empty),
    .frame(frame), .take(ser_take), .sdo(sdo)
  );

  assign buf_full = fifo_full;
endmodule

// File: rtl/rdo_checks.sv
module rdo_checks #(
  parameter int N_CH = 128,
  parameter int AW   = 8
) (
  input logic            clk,
  input logic            rst_s,
  input logic            fast_rst,
  input logic            l1_trig,
  input logic            hit_mode,
  input logic            buf_full,
  input logic            sdo,
  input logic            ovf_q,
  input logic [AW-1:0]   wr_ptr,
  input logic [N_CH-1:0] hit_w
);
  assert_fast_reset_R10: assert property (@(posedge clk) disable iff (!rst_s)
    fast_rst |=> (!buf_full && !sdo && !ovf_q));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (ovf_q && !fast_rst) |=> ovf_q);

  assert_ovf_set_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (l1_trig && buf_full && !fast_rst) |=> ovf_q);

  assert_full_after_trig_R7: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(buf_full) |-> $past(l1_trig));

  assert_wr_advance_R5: assert property (@(posedge clk) disable iff (!rst_s)
    !fast_rst |=> wr_ptr == AW'($past(wr_ptr) + 1'b1));

  assert_wr_restart_R5: assert property (@(posedge clk) disable iff (!rst_s)
    fast_rst |=> wr_ptr == '0);

  assert_edge_pulse_R2: assert property (@(posedge clk) disable iff (!rst_s)
    !$past(hit_mode) |-> ((hit_w & $past(hit_w)) == '0));
endmodule

bind l1_hit_readout rdo_checks #(.N_CH(N_CH), .AW(AW)) i_checks (
  .clk(clk), .rst_s(rst_s), .fast_rst(fast_rst), .l1_trig(l1_trig),
  .hit_mode(hit_mode), .buf_full(buf_full), .sdo(sdo), .ovf_q(ovf_q),
  .wr_ptr(wr_ptr), .hit_w(hit_w)
);

// File: tb/test_l1_hit_readout.sv
module test_l1_hit_readout;
  localparam int NC = 128;
  localparam int FL = 140;
  localparam time TP = 20ns;

  typedef struct {
    int           start;
    bit           prime;
    logic [7:0]   addr;
    logic [NC-1:0] data;
    string        tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, fast_rst = 1'b0, l1_trig = 1'b0, hit_mode = 1'b1;
  logic [7:0] latency = 8'd0;
  logic [NC-1:0] comp_in = '0;
  logic sdo, buf_full;

  int cyc = 0, n_chk = 0, n_err = 0;
  int fr_edge = -1, ovf_edge = -1, last_start = -100000;
  int starts[$];
  exp_t q[$];
  logic [NC-1:0] comp_hist [int];
  bit mode_hist [int];
  bit gen_on = 1'b0;
  logic [31:0] lf = 32'h1234_5678;
  bit done = 1'b0;

  l1_hit_readout i_l1_hit_readout (
    .clk(clk), .rst_n(rst_n), .fast_rst(fast_rst), .l1_trig(l1_trig),
    .hit_mode(hit_mode), .latency(latency), .comp_in(comp_in),
    .sdo(sdo), .buf_full(buf_full)
  );

  always #(TP/2) clk = ~clk;

  always @(posedge clk) begin
    comp_hist[cyc+1] = comp_in;
    mode_hist[cyc+1] = hit_mode;
    cyc <= cyc + 1;
  end

  function automatic logic [31:0] xs(input logic [31:0] v);
    logic [31:0] r;
    r = v ^ (v << 13);
    r = r ^ (r >> 17);
    return r ^ (r << 5);
  endfunction

  always @(negedge clk) begin
    if (gen_on) begin
      logic [NC-1:0] v;
      for (int k = 0; k < NC/32; k++) begin
        lf = xs(lf);
        v[k*32 +: 32] = lf;
      end
      comp_in = v;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [NC-1:0] act, input logic [NC-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] hitval(input int s);
    logic [NC-1:0] c, p;
    c = comp_hist.exists(s) ? comp_hist[s] : '0;
    p = comp_hist.exists(s-1) ? comp_hist[s-1] : '0;
    return (mode_hist.exists(s) && mode_hist[s]) ? c : (c & ~p);
  endfunction

  // called at a negedge: prepares a trigger sampled at edge cyc+1
  task automatic trig_now(input logic [7:0] lat, input string tag);
    int t, le, occ, st, a;
    exp_t e;
    t = cyc + 1;
    le = (lat == 0) ? 256 : int'(lat);
    occ = starts.size();
    foreach (starts[i]) if (starts[i] < t) occ--;
    latency = lat;
    l1_trig = 1'b1;
    if (occ >= 32) begin
      if (ovf_edge < 0) ovf_edge = t;
    end else begin
      st = (t + 1 > last_start + FL) ? t + 1 : last_start + FL;
      last_start = st;
      starts.push_back(st);
      a = ((t - fr_edge - 1 - le) % 256 + 256) % 256;
      e.start = st;
      e.prime = (t - fr_edge - 1) < le;
      e.addr = 8'(a);
      e.data = hitval(t - le - 1);
      e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic do_fast_reset;
    @(negedge clk);
    fast_rst = 1'b1;
    fr_edge = cyc + 1;
    q.delete();
    starts.delete();
    ovf_edge = -1;
    last_start = -100000;
    @(negedge clk);
    fast_rst = 1'b0;
    check(sdo == 1'b0, "R10", "sdo after fast reset", NC'(sdo), '0);
    check(buf_full == 1'b0, "R10", "buf_full after fast reset", NC'(buf_full), '0);
  endtask

  task automatic single_trig(input logic [7:0] lat, input string tag);
    @(negedge clk);
    trig_now(lat, tag);
    @(negedge clk);
    l1_trig = 1'b0;
  endtask

  // monitor: samples a quarter period after each rising edge
  bit in_fr = 1'b0;
  int nb = 0, fstart = 0;
  logic [FL-1:0] got;
  always @(posedge clk) begin
    #(TP/4);
    if (cyc == fr_edge) begin
      in_fr = 1'b0;
      nb = 0;
    end else if (in_fr || sdo) begin
      if (!in_fr) begin
        in_fr = 1'b1;
        fstart = cyc;
        nb = 0;
      end
      got = {got[FL-2:0], sdo};
      nb++;
      if (nb == FL) begin
        in_fr = 1'b0;
        if (q.size() == 0) begin
          check(1'b0, "R6", "unexpected frame", NC'(fstart), '0);
        end else begin
          exp_t e;
          bit ov;
          e = q.pop_front();
          ov = (ovf_edge >= 0) && (e.start > ovf_edge);
          check(fstart == e.start, "R6", "frame start edge", NC'(fstart), NC'(e.start));
          check(got[FL-1:FL-2] == 2'b11, "R4", "start marker", NC'(got[FL-1:FL-2]), NC'(2'b11));
          check(got[FL-3] == ov, "R8", "overflow bit", NC'(got[FL-3]), NC'(ov));
          check(got[FL-4] == e.prime, "R9", "priming bit", NC'(got[FL-4]), NC'(e.prime));
          check(got[FL-5:FL-12] == e.addr, "R5", "pipeline address", NC'(got[FL-5:FL-12]), NC'(e.addr));
          if (!e.prime)
            check(got[NC-1:0] == e.data, e.tag, "channel bits", got[NC-1:0], e.data);
        end
      end
    end
  end

  initial begin
    #(TP * 200000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sdo == 1'b0, "R6", "sdo in reset", NC'(sdo), '0);
    check(buf_full == 1'b0, "R7", "buf_full in reset", NC'(buf_full), '0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    do_fast_reset();
    gen_on = 1'b1;
    hit_mode = 1'b1;
    repeat (300) @(negedge clk);
    // R1 / R3: level mode, several latencies including the minimum and full depth
    single_trig(8'd20, "R1");
    repeat (10) @(negedge clk);
    single_trig(8'd1, "R3");
    repeat (10) @(negedge clk);
    single_trig(8'd0, "R3");
    single_trig(8'd255, "R3");
    repeat (400) @(negedge clk);
    // R2: edge mode
    hit_mode = 1'b0;
    repeat (30) @(negedge clk);
    single_trig(8'd7, "R2");
    repeat (5) @(negedge clk);
    single_trig(8'd2, "R2");
    repeat (400) @(negedge clk);
    hit_mode = 1'b1;
    // R9: priming flag right after a fast reset
    do_fast_reset();
    // fast reset edge f; now at negedge after edge f; next edge f+1
    repeat (2) @(negedge clk);
    @(negedge clk);
    trig_now(8'd3, "R9");
    @(negedge clk);
    trig_now(8'd10, "R9");
    @(negedge clk);
    l1_trig = 1'b0;
    repeat (400) @(negedge clk);
    // R7 / R8: burst of 40 triggers to fill the buffer
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      trig_now(8'd10, "R3");
    end
    @(negedge clk);
    l1_trig = 1'b0;
    check(buf_full == 1'b1, "R7", "buf_full after burst", NC'(buf_full), NC'(1));
    repeat (FL * 3 + 20) @(negedge clk);
    check(buf_full == 1'b0, "R7", "buf_full after draining", NC'(buf_full), '0);
    // R10: fast reset in the middle of a frame with a loaded buffer
    do_fast_reset();
    repeat (50) @(negedge clk);
    check(sdo == 1'b0, "R10", "no old frame after fast reset", NC'(sdo), '0);
    single_trig(8'd12, "R10");
    repeat (FL + 20) @(negedge clk);
    check(q.size() == 0, "R6", "frames outstanding", NC'(q.size()), '0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule